// File: doc/BRIEF.md
# Paired-Ring Memory Copy Engine

This block moves data from one memory region to another under the control of two descriptor rings in shared memory. Both rings have the same power-of-two number of entries. An entry in the source ring names a source address and a length. The entry at the same position in the destination ring names a destination address, and the engine marks it complete when the copy is done. Software fills the entries and then moves its producer index forward. The engine walks the entries at its own hardware index and copies each segment one 32-bit word at a time. It writes a completion word into the destination entry, moves both hardware indices forward, and gives a one-cycle pulse that interrupt logic can count.

Software hands finished destination entries back by writing a separate reclaim index. The engine never starts an entry whose destination slot has not been reclaimed. Software can stop new work by clearing either ring enable. The entry already in progress still runs to completion, and the busy flags show when it has. Each ring's hardware index can be forced back to zero through a reset register.

Top module: `ring_copy_dma`

## Requirements
- R1: After reset, reads return the following values. Source producer index (0x008): 0. Reclaim index (0x108): DEPTH-1. Both hardware indices (0x00C, 0x10C): 0. Both counts (0x004, 0x104): DEPTH. Global register (0x204): 0. Reset register (0x208): 0.
- R2: Register addresses are as follows. The source ring bank is at 0x000: base, count, producer index, hardware index. The destination ring bank uses the same layout at 0x100. Base and count read back what was written. Writes to a hardware index register have no effect.
- R3: The entry for index i starts at base + 16*i. Word offset +0 holds the address. In word offset +4, bits 29:16 hold the byte length, a multiple of 4.
- R4: A new entry starts only when all of these hold: both enables are set, the source hardware index differs from the producer index, and the destination hardware index differs from the reclaim index. The engine reads source +0, then source +4, then destination +0. It then copies length/4 words in ascending address order, each as a read followed by a write. A zero length copies nothing.
- R5: After the last copy write, the engine writes destination word +4 with the length in bits 29:16, bit 31 set and every other bit clear.
- R6: After that write-back, done_pulse is high for exactly one cycle. Both hardware indices then become (i+1) & (count-1), where count is the source ring count, so they wrap at the count.
- R7: When the destination hardware index equals the reclaim index, the engine stalls without touching memory. It resumes once the reclaim index is moved.
- R8: In the global register (0x204), bit 0 enables the source side and bit 2 enables the destination side. With either bit clear, no entry starts. Clearing them while an entry is in flight lets that entry finish.
- R9: Global bit 1 is high while the source side is busy: source fetch and copy. Global bit 3 is high while the destination side is busy: destination fetch, copy and write-back. Both bits read 0 when the engine is idle.
- R10: In the reset register (0x208), bit 0 holds the source hardware index at 0 while it is set, and bit 16 does the same for the destination hardware index. Neither bit changes any other register.
- R11: The memory port has one access outstanding at a time. mem_req, mem_we, mem_addr and mem_wdata stay stable until mem_ack is high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Access accepted/completed |
| done_pulse | output | 1 | One-cycle pulse per completed entry |

## Verification
The copy path is tried with a batch of entries of mixed lengths, including a zero-length one. This separates the write-back-only path from the real copy loop. A second batch runs into the unreclaimed destination slot and then wraps past the end of the ring. This separates the stall decision from the producer-index comparison, and tests the index masking. A long entry submitted with the enables cleared, then started and stopped mid-copy, separates the start gate from draining the entry in flight. It also makes the busy flags visible. Every memory write is compared in order with a behavioural queue of expected writes.

// File: rtl/ring_copy_pkg.sv
package ring_copy_pkg;
  localparam logic [11:0] OFS_BASE   = 12'h000;
  localparam logic [11:0] OFS_CNT    = 12'h004;
  localparam logic [11:0] OFS_CPU    = 12'h008;
  localparam logic [11:0] OFS_HWIDX  = 12'h00C;
  localparam logic [11:0] RING_STEP  = 12'h100;
  localparam logic [11:0] OFS_GLOBAL = 12'h204;
  localparam logic [11:0] OFS_RESET  = 12'h208;

  localparam int LEN_LSB  = 16;
  localparam int LEN_W    = 14;
  localparam int WORDS_W  = LEN_W - 2;
  localparam int DONE_BIT = 31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SRC, ST_LEN, ST_DST, ST_CRD, ST_CWR, ST_WB, ST_ADV
  } eng_state_t;
endpackage

// File: rtl/ring_copy_regs.sv
module ring_copy_regs
  import ring_copy_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [11:0]      reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             adv,
  input  logic             tx_busy,
  input  logic             rx_busy,
  output logic [31:0]      tx_base,
  output logic [31:0]      rx_base,
  output logic [IDX_W-1:0] idx_mask,
  output logic [IDX_W-1:0] tx_cpu,
  output logic [IDX_W-1:0] rx_cpu,
  output logic [IDX_W-1:0] tx_dma,
  output logic [IDX_W-1:0] rx_dma,
  output logic             tx_en,
  output logic             rx_en,
  output logic             tx_clr,
  output logic             rx_clr
);
  localparam int CNT_W = IDX_W + 1;

  logic [31:0]      base_v [2];
  logic [CNT_W-1:0] cnt_v  [2];
  logic [IDX_W-1:0] cpu_v  [2];
  logic [IDX_W-1:0] dma_v  [2];
  logic [1:0]       en_q, en_d, clr_q, clr_d;

  assign idx_mask = IDX_W'(cnt_v[0] - CNT_W'(1));

  // one register bank per ring; ring r sits at r * RING_STEP
  for (genvar r = 0; r < 2; r++) begin : g_ring
    localparam logic [11:0] OFS = 12'(r * 256);
    localparam logic [IDX_W-1:0] CPU_RST = (r == 0) ? '0 : IDX_W'(DEPTH - 1);
    logic [31:0]      base_q, base_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [IDX_W-1:0] cpu_q, cpu_d, dma_q, dma_d;

    always_comb begin
      base_d = base_q;
      cnt_d  = cnt_q;
      cpu_d  = cpu_q;
      dma_d  = dma_q;
      if (reg_we && reg_addr == OFS + OFS_BASE) base_d = reg_wdata;
      if (reg_we && reg_addr == OFS + OFS_CNT)  cnt_d  = reg_wdata[CNT_W-1:0];
      if (reg_we && reg_addr == OFS + OFS_CPU)  cpu_d  = reg_wdata[IDX_W-1:0];
      if (clr_q[r])  dma_d = '0;
      else if (adv)  dma_d = (dma_q + 1'b1) & idx_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        cnt_q  <= CNT_W'(DEPTH);
        cpu_q  <= CPU_RST;
        dma_q  <= '0;
      end else begin
        base_q <= base_d;
        cnt_q  <= cnt_d;
        cpu_q  <= cpu_d;
        dma_q  <= dma_d;
      end
    end

    assign base_v[r] = base_q;
    assign cnt_v[r]  = cnt_q;
    assign cpu_v[r]  = cpu_q;
    assign dma_v[r]  = dma_q;
  end

  always_comb begin
    en_d  = en_q;
    clr_d = clr_q;
    if (reg_we && reg_addr == OFS_GLOBAL) en_d  = {reg_wdata[2], reg_wdata[0]};
    if (reg_we && reg_addr == OFS_RESET)  clr_d = {reg_wdata[16], reg_wdata[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      clr_q <= '0;
    end else begin
      en_q  <= en_d;
      clr_q <= clr_d;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_BASE:               reg_rdata = base_v[0];
      OFS_CNT:                reg_rdata = 32'(cnt_v[0]);
      OFS_CPU:                reg_rdata = 32'(cpu_v[0]);
      OFS_HWIDX:              reg_rdata = 32'(dma_v[0]);
      RING_STEP + OFS_BASE:   reg_rdata = base_v[1];
      RING_STEP + OFS_CNT:    reg_rdata = 32'(cnt_v[1]);
      RING_STEP + OFS_CPU:    reg_rdata = 32'(cpu_v[1]);
      RING_STEP + OFS_HWIDX:  reg_rdata = 32'(dma_v[1]);
      OFS_GLOBAL:             reg_rdata = {28'd0, rx_busy, en_q[1], tx_busy, en_q[0]};
      OFS_RESET:              reg_rdata = {15'd0, clr_q[1], 15'd0, clr_q[0]};
      default:                reg_rdata = '0;
    endcase
  end

  assign tx_base = base_v[0];
  assign rx_base = base_v[1];
  assign tx_cpu  = cpu_v[0];
  assign rx_cpu  = cpu_v[1];
  assign tx_dma  = dma_v[0];
  assign rx_dma  = dma_v[1];
  assign tx_en   = en_q[0];
  assign rx_en   = en_q[1];
  assign tx_clr  = clr_q[0];
  assign rx_clr  = clr_q[1];
endmodule

// File: rtl/ring_copy_engine.sv
module ring_copy_engine
  import ring_copy_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic [31:0]      tx_base,
  input  logic [31:0]      rx_base,
  input  logic [IDX_W-1:0] tx_cpu,
  input  logic [IDX_W-1:0] rx_cpu,
  input  logic [IDX_W-1:0] tx_dma,
  input  logic [IDX_W-1:0] rx_dma,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack,
  output logic             adv,
  output logic             tx_busy,
  output logic             rx_busy
);
  eng_state_t         state_q, state_d;
  logic [31:0]        src_q, src_d, dst_q, dst_d, data_q, data_d;
  logic [LEN_W-1:0]   len_q, len_d;
  logic [WORDS_W-1:0] words_q, words_d;
  logic [31:0]        tx_entry, rx_entry;
  logic               can_start;

  assign tx_entry  = tx_base + {{(28-IDX_W){1'b0}}, tx_dma, 4'b0000};
  assign rx_entry  = rx_base + {{(28-IDX_W){1'b0}}, rx_dma, 4'b0000};
  assign can_start = tx_en && rx_en && (tx_dma != tx_cpu) && (rx_dma != rx_cpu);

  always_comb begin
    state_d   = state_q;
    src_d     = src_q;
    dst_d     = dst_q;
    data_d    = data_q;
    len_d     = len_q;
    words_d   = words_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    adv       = 1'b0;
    unique case (state_q)
      ST_IDLE: if (can_start) state_d = ST_SRC;
      ST_SRC: begin
        mem_req  = 1'b1;
        mem_addr = tx_entry;
        if (mem_ack) begin
          src_d   = mem_rdata;
          state_d = ST_LEN;
        end
      end
      ST_LEN: begin
        mem_req  = 1'b1;
        mem_addr = tx_entry + 32'd4;
        if (mem_ack) begin
          len_d   = mem_rdata[LEN_LSB +: LEN_W];
          words_d = mem_rdata[LEN_LSB+2 +: WORDS_W];
          state_d = ST_DST;
        end
      end
      ST_DST: begin
        mem_req  = 1'b1;
        mem_addr = rx_entry;
        if (mem_ack) begin
          dst_d   = mem_rdata;
          state_d = (words_q == '0) ? ST_WB : ST_CRD;
        end
      end
      ST_CRD: begin
        mem_req  = 1'b1;
        mem_addr = src_q;
        if (mem_ack) begin
          data_d  = mem_rdata;
          state_d = ST_CWR;
        end
      end
      ST_CWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst_q;
        mem_wdata = data_q;
        if (mem_ack) begin
          src_d   = src_q + 32'd4;
          dst_d   = dst_q + 32'd4;
          words_d = words_q - 1'b1;
          state_d = (words_q == WORDS_W'(1)) ? ST_WB : ST_CRD;
        end
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = rx_entry + 32'd4;
        mem_wdata = {1'b1, 1'b0, len_q, 16'd0};
        if (mem_ack) state_d = ST_ADV;
      end
      ST_ADV: begin
        adv     = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      data_q  <= '0;
      len_q   <= '0;
      words_q <= '0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      data_q  <= data_d;
      len_q   <= len_d;
      words_q <= words_d;
    end
  end

  assign tx_busy = (state_q == ST_SRC) || (state_q == ST_LEN) || (state_q == ST_DST) ||
                   (state_q == ST_CRD) || (state_q == ST_CWR);
  assign rx_busy = (state_q == ST_DST) || (state_q == ST_CRD) || (state_q == ST_CWR) ||
                   (state_q == ST_WB);
endmodule

// File: rtl/ring_copy_dma.sv
module ring_copy_dma #(
  parameter int IDX_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic        done_pulse
);
  localparam int DEPTH = 1 << IDX_W;

  logic [31:0]      tx_base, rx_base;
  logic [IDX_W-1:0] idx_mask, tx_cpu, rx_cpu, tx_dma, rx_dma;
  logic             tx_en, rx_en, tx_clr, rx_clr, tx_busy, rx_busy, adv;

  ring_copy_regs #(.IDX_W(IDX_W), .DEPTH(DEPTH)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adv(adv),
    .tx_busy(tx_busy), .rx_busy(rx_busy), .tx_base(tx_base), .rx_base(rx_base),
    .idx_mask(idx_mask), .tx_cpu(tx_cpu), .rx_cpu(rx_cpu), .tx_dma(tx_dma),
    .rx_dma(rx_dma), .tx_en(tx_en), .rx_en(rx_en), .tx_clr(tx_clr), .rx_clr(rx_clr)
  );

  ring_copy_engine #(.IDX_W(IDX_W)) eng_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
    .tx_base(tx_base), .rx_base(rx_base), .tx_cpu(tx_cpu), .rx_cpu(rx_cpu),
    .tx_dma(tx_dma), .rx_dma(rx_dma), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .adv(adv), .tx_busy(tx_busy), .rx_busy(rx_busy)
  );

  assign done_pulse = adv;
endmodule

// File: rtl/ring_copy_dma_chk.sv
module ring_copy_dma_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done_pulse,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [31:0]      mem_addr,
  input logic [31:0]      mem_wdata,
  input logic [IDX_W-1:0] tx_dma,
  input logic [IDX_W-1:0] rx_dma,
  input logic [IDX_W-1:0] rx_cpu,
  input logic [IDX_W-1:0] idx_mask,
  input logic             tx_en,
  input logic             rx_en,
  input logic             tx_clr,
  input logic             tx_busy,
  input logic             rx_busy
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  assert_index_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && !tx_clr) |=> tx_dma == (($past(tx_dma) + 1'b1) & $past(idx_mask)));

  assert_no_start_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> ($past(rx_dma) != $past(rx_cpu)));

  assert_gate_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !rx_busy && !(tx_en && rx_en)) |=> !tx_busy);

  assert_wb_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !tx_busy) |-> (mem_wdata[31] && !mem_wdata[30] && mem_wdata[15:0] == 16'd0));
endmodule

bind ring_copy_dma ring_copy_dma_chk #(.IDX_W(IDX_W)) chk_i (.*);

// File: tb/ring_copy_dma_tb_top.sv
module ring_copy_dma_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        done_pulse;

  int unsigned mem [0:4095];
  int unsigned exp_a[$];
  int unsigned exp_d[$];
  int n_chk = 0, n_fail = 0, n_done = 0, n_acc = 0, exp_acc = 0;

  always #4 clk = ~clk;

  ring_copy_dma dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .done_pulse(done_pulse)
  );

  // behavioural memory: accepts a request one cycle after it appears
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[13:2]];
      if (mem_we) mem[mem_addr[13:2]] = mem_wdata;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference comparison every clock: each write must match the expected queue head
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_pulse) n_done++;
      if (mem_req && !mem_ack) begin
        n_acc++;
        if (mem_we) begin
          if (exp_a.size() == 0) begin
            check(1'b0, "R4 unexpected write", mem_addr, 32'hFFFF_FFFF);
          end else begin
            check(mem_addr == exp_a[0], "R3/R4/R5 write address", mem_addr, exp_a[0]);
            check(mem_wdata == exp_d[0], "R4/R5 write data", mem_wdata, exp_d[0]);
            void'(exp_a.pop_front());
            void'(exp_d.pop_front());
          end
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    check(v == exp, tag, v, exp);
  endtask

  task automatic wait_idx(input int target);
    logic [31:0] v, g;
    for (int i = 0; i < 3000; i++) begin
      rd(12'h00C, v);
      if (v == 32'(target)) begin
        rd(12'h204, g);
        if (!g[1] && !g[3]) break;
      end
    end
  endtask

  // source ring at 0x1000, destination ring at 0x1800
  task automatic add_desc(input int idx, input int unsigned src, input int unsigned dst, input int len);
    mem[(32'h1000 + 16*idx) >> 2]     = src;
    mem[(32'h1004 + 16*idx) >> 2]     = (len << 16) | 32'h4000_0000;
    mem[(32'h1800 + 16*idx) >> 2]     = dst;
    mem[(32'h1804 + 16*idx) >> 2]     = 0;
    for (int w = 0; w < len/4; w++) begin
      mem[(src >> 2) + w] = 32'hA500_0000 ^ (src + 4*w) ^ (idx << 20);
      exp_a.push_back(dst + 4*w);
      exp_d.push_back(32'hA500_0000 ^ (src + 4*w) ^ (idx << 20));
    end
    exp_a.push_back(32'h1804 + 16*idx);
    exp_d.push_back((len << 16) | 32'h8000_0000);
    exp_acc += 4 + 2*(len/4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(12'h008, 32'd0,  "R1 tx producer index");
    rd_chk(12'h108, 32'd15, "R1 reclaim index");
    rd_chk(12'h00C, 32'd0,  "R1 tx hw index");
    rd_chk(12'h10C, 32'd0,  "R1 rx hw index");
    rd_chk(12'h004, 32'd16, "R1 tx count");
    rd_chk(12'h204, 32'd0,  "R1 global");
    rd_chk(12'h208, 32'd0,  "R1 reset reg");

    // R2 map and read-only hardware index
    wr(12'h00C, 32'd5);
    rd_chk(12'h00C, 32'd0, "R2 hw index read-only");
    wr(12'h000, 32'h1000);
    wr(12'h100, 32'h1800);
    rd_chk(12'h000, 32'h1000, "R2 tx base");
    rd_chk(12'h100, 32'h1800, "R2 rx base");
    wr(12'h004, 32'd8);
    wr(12'h104, 32'd8);
    wr(12'h108, 32'd7);
    rd_chk(12'h104, 32'd8, "R2 rx count");
    wr(12'h204, 32'h5);

    // batch 1: mixed lengths including zero
    add_desc(0, 32'h2000, 32'h3000, 16);
    add_desc(1, 32'h2100, 32'h3100, 0);
    add_desc(2, 32'h2200, 32'h3200, 32);
    wr(12'h008, 32'd3);
    wait_idx(3);
    rd_chk(12'h00C, 32'd3, "R6 tx hw index after batch");
    rd_chk(12'h10C, 32'd3, "R6 rx hw index after batch");
    check(n_done == 3, "R6 done pulses batch 1", 32'(n_done), 32'd3);
    check(exp_a.size() == 0, "R4 batch 1 writes complete", 32'(exp_a.size()), 32'd0);

    // batch 2: run into unreclaimed slot, then wrap
    for (int k = 0; k < 6; k++)
      add_desc((3 + k) % 8, 32'h2400 + 32'h40*k, 32'h3400 + 32'h40*k, 4);
    wr(12'h008, 32'd1);
    wait_idx(7);
    rd_chk(12'h10C, 32'd7, "R7 rx index stops at reclaim index");
    repeat (30) @(negedge clk);
    rd_chk(12'h00C, 32'd7, "R7 stalled tx index");
    check(exp_a.size() == 4, "R7 no writes while full", 32'(exp_a.size()), 32'd4);
    check(n_done == 7, "R7 done pulses before stall", 32'(n_done), 32'd7);
    wr(12'h108, 32'd2);
    wait_idx(1);
    rd_chk(12'h10C, 32'd1, "R6 wrapped rx index");
    check(n_done == 9, "R6 done pulses after wrap", 32'(n_done), 32'd9);
    check(exp_a.size() == 0, "R7 resumed writes complete", 32'(exp_a.size()), 32'd0);

    // enables: gate start, drain in flight
    wr(12'h204, 32'h0);
    add_desc(1, 32'h2800, 32'h3800, 64);
    wr(12'h008, 32'd2);
    repeat (40) @(negedge clk);
    rd_chk(12'h00C, 32'd1, "R8 no start while disabled");
    check(exp_a.size() == 17, "R8 no writes while disabled", 32'(exp_a.size()), 32'd17);
    wr(12'h204, 32'h5);
    repeat (12) @(negedge clk);
    rd_chk(12'h204, 32'hF, "R9 both busy during copy");
    wr(12'h204, 32'h0);
    rd_chk(12'h204, 32'hA, "R8 busy held after disable");
    wait_idx(2);
    rd_chk(12'h204, 32'h0, "R9 busy clear when idle");
    check(n_done == 10, "R8 in-flight entry drained", 32'(n_done), 32'd10);
    check(exp_a.size() == 0, "R8 drain writes complete", 32'(exp_a.size()), 32'd0);

    // per-ring index reset
    wr(12'h208, 32'h1);
    wr(12'h208, 32'h0);
    rd_chk(12'h00C, 32'd0, "R10 tx hw index cleared");
    rd_chk(12'h10C, 32'd2, "R10 rx hw index untouched");
    wr(12'h208, 32'h1_0000);
    wr(12'h208, 32'h0);
    rd_chk(12'h10C, 32'd0, "R10 rx hw index cleared");
    rd_chk(12'h008, 32'd2, "R10 producer index untouched");

    check(n_acc == exp_acc, "R11 one access per handshake", 32'(n_acc), 32'(exp_acc));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule